// File: doc/BRIEF.md
# Bus-Mapped Configurable Pin Port

This block is a small pin controller that a microcontroller programs through a synchronous register bus. It watches the bus address and responds only inside a 256-byte page whose upper address bits match a fixed base, set by parameter. Inside that page, a few word offsets select the configuration and data registers of the port. All other offsets read as zero.

Each pin has its own set of controls. A mode bit picks between a software-driven general-purpose pin and a pin that drives a latched address bit. A direction bit sets whether the pin drives in general-purpose mode. A drive bit picks push-pull or open-drain output. An input mask marks pins that belong to the programmable logic fabric. On those pins the port takes its hands off the pad driver completely.

The block also gives read access to three sources. The first is the synchronized pin levels. The second is the fabric-ownership mask. The third is the current outputs of the fabric macrocells.

Top module: `cfg_io_port`

## Requirements
- R1: After reset, the mode, direction, data-out and drive registers all read 0x00. Every pin not masked to the fabric drives the latched address bit, which resets to 0, with its output enable high.
- R2: A bus access is accepted only when bus_addr[ADDR_W-1:8] equals the upper bits of the base address. A write outside the page changes nothing. A read outside the page returns 0x00.
- R3: The registers at page offsets 0x02 (mode), 0x04 (data-out), 0x06 (direction) and 0x08 (drive select) take the write data on the clock edge of a write. A read returns their stored value with no wait cycle.
- R4: A read of any offset other than 0x00, 0x02, 0x04, 0x06, 0x08, 0x0A or 0x0C returns 0x00. A write to such an offset changes no register and no pad.
- R5: Offset 0x0A returns the fabric-ownership mask, where bit n = 1 means pin n belongs to the fabric. Writes to it have no effect.
- R6: Offset 0x0C returns the macrocell outputs as they are presented on the mcell_out input. Writes to it have no effect.
- R7: Offset 0x00 returns the pin levels after a two-flop synchronizer. A level change on pin_in first shows in the read on the second clock edge after it. A bit reads 0 when its pin is in address mode (mode bit 0) or is owned by the fabric.
- R8: A pin in general-purpose mode (mode bit 1) with push-pull drive (drive bit 0) behaves as follows. With direction bit 1, the output enable is high and the pad value equals its data-out bit. With direction bit 0, the output enable is low.
- R9: A driving pin with open-drain drive (drive bit 1) works as follows. When its value is 0, pad_oe is 1 and pad_out is 0. When its value is 1, pad_oe is 0.
- R10: A pin in address mode (mode bit 0) drives the bit of the address latch for that pin, whatever its direction bit says. The latch loads addr_src on a clock edge where addr_le is high and holds otherwise.
- R11: A pin whose fabric mask bit is 1 has pad_oe 0 and pad_out 0 in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Bus address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, qualifies bus_rdata |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from the address |
| addr_le | input | 1 | Address latch load enable |
| addr_src | input | NUM_PINS | Address bits captured by the latch |
| pld_mask | input | NUM_PINS | Fabric-ownership mask, 1 = owned by fabric |
| mcell_out | input | NUM_PINS | Macrocell outputs for read-back |
| pin_in | input | NUM_PINS | Asynchronous pad input levels |
| pad_out | output | NUM_PINS | Pad drive value |
| pad_oe | output | NUM_PINS | Pad output enable |

## Verification
The bench builds the port with eight pins on an eight-bit bus. It uses a 16-bit address with the base page at 0xA500 and turns open-drain support on. With eight pins, every data bit is a live pin, so a wrong bit slice in the read mux or the pad logic shows up in the patterns. The base page is away from zero, so writes and reads one page above and one page below can be checked against the page compare. Because the drive-select register is built in, the open-drain path and its interaction with direction and with the fabric mask can be reached.

// File: rtl/cfg_io_pkg.sv
package cfg_io_pkg;

   // Page offsets of the port registers (low address byte).
   localparam logic [7:0] OFS_PIN_LVL = 8'h00;
   localparam logic [7:0] OFS_MODE    = 8'h02;
   localparam logic [7:0] OFS_DOUT    = 8'h04;
   localparam logic [7:0] OFS_DIR     = 8'h06;
   localparam logic [7:0] OFS_DRIVE   = 8'h08;
   localparam logic [7:0] OFS_FABRIC  = 8'h0A;
   localparam logic [7:0] OFS_MCELL   = 8'h0C;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_PIN_LVL,
      SEL_MODE,
      SEL_DOUT,
      SEL_DIR,
      SEL_DRIVE,
      SEL_FABRIC,
      SEL_MCELL
   } port_sel_e;

   function automatic port_sel_e decode_offset(input logic [7:0] ofs);
      port_sel_e s;
      case (ofs)
         OFS_PIN_LVL: s = SEL_PIN_LVL;
         OFS_MODE:    s = SEL_MODE;
         OFS_DOUT:    s = SEL_DOUT;
         OFS_DIR:     s = SEL_DIR;
         OFS_DRIVE:   s = SEL_DRIVE;
         OFS_FABRIC:  s = SEL_FABRIC;
         OFS_MCELL:   s = SEL_MCELL;
         default:     s = SEL_NONE;
      endcase
      return s;
   endfunction

endpackage

// File: rtl/cfg_io_sync.sv
module cfg_io_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] q_sync
);

   if (STAGES < 2) begin : g_bad_stages
      $error("cfg_io_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][WIDTH-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[0] <= '0;
      else        chain_q[0] <= d_async;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q[s] <= '0;
         else        chain_q[s] <= chain_q[s-1];
      end
   end

   assign q_sync = chain_q[STAGES-1];

   // First stage captures the raw pin level on every edge.
   assert_sync_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> chain_q[0] == $past(d_async));

   // Last stage follows the stage before it.
   assert_sync_shift_R7: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> q_sync == $past(chain_q[STAGES-2]));

endmodule

// File: rtl/cfg_io_regs.sv
module cfg_io_regs
   import cfg_io_pkg::*;
#(
   parameter int                NUM_PINS   = 8,
   parameter int                DATA_W     = 8,
   parameter int                ADDR_W     = 16,
   parameter logic [ADDR_W-1:0] BASE_ADDR  = 16'h0300,
   parameter bit                OD_SUPPORT = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic                bus_wr,
   input  logic                bus_rd,
   input  logic [DATA_W-1:0]   bus_wdata,
   output logic [DATA_W-1:0]   bus_rdata,
   input  logic [NUM_PINS-1:0] pin_sync,
   input  logic [NUM_PINS-1:0] pld_mask,
   input  logic [NUM_PINS-1:0] mcell_out,
   output logic [NUM_PINS-1:0] mode_q,
   output logic [NUM_PINS-1:0] dir_q,
   output logic [NUM_PINS-1:0] dout_q,
   output logic [NUM_PINS-1:0] drive_q
);

   localparam int PAGE_LSB = 8;

   logic                page_hit;
   port_sel_e           sel;
   logic [NUM_PINS-1:0] wr_bits;
   logic [NUM_PINS-1:0] pin_view;
   logic [NUM_PINS-1:0] rd_bits;

   assign page_hit = (bus_addr[ADDR_W-1:PAGE_LSB] == BASE_ADDR[ADDR_W-1:PAGE_LSB]);
   assign sel      = page_hit ? decode_offset(bus_addr[PAGE_LSB-1:0]) : SEL_NONE;
   assign wr_bits  = bus_wdata[NUM_PINS-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= '0;
         dir_q  <= '0;
         dout_q <= '0;
      end else if (bus_wr) begin
         case (sel)
            SEL_MODE: mode_q <= wr_bits;
            SEL_DIR:  dir_q  <= wr_bits;
            SEL_DOUT: dout_q <= wr_bits;
            default:  ;
         endcase
      end
   end

   if (OD_SUPPORT) begin : g_drive_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                         drive_q <= '0;
         else if (bus_wr && sel == SEL_DRIVE) drive_q <= wr_bits;
      end
   end else begin : g_drive_none
      assign drive_q = '0;
   end

   // Pin levels are visible only for general-purpose pins not owned by the fabric.
   assign pin_view = pin_sync & mode_q & ~pld_mask;

   always_comb begin
      case (sel)
         SEL_PIN_LVL: rd_bits = pin_view;
         SEL_MODE:    rd_bits = mode_q;
         SEL_DOUT:    rd_bits = dout_q;
         SEL_DIR:     rd_bits = dir_q;
         SEL_DRIVE:   rd_bits = drive_q;
         SEL_FABRIC:  rd_bits = pld_mask;
         SEL_MCELL:   rd_bits = mcell_out;
         default:     rd_bits = '0;
      endcase
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_rd) bus_rdata[NUM_PINS-1:0] = rd_bits;
   end

   assert_mode_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && page_hit && bus_addr[PAGE_LSB-1:0] == OFS_MODE)
      |=> mode_q == $past(bus_wdata[NUM_PINS-1:0]));

   assert_dir_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && page_hit && bus_addr[PAGE_LSB-1:0] == OFS_DIR)
      |=> dir_q == $past(bus_wdata[NUM_PINS-1:0]));

   assert_off_page_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !page_hit |=> $stable(mode_q) && $stable(dir_q) && $stable(dout_q) && $stable(drive_q));

   assert_off_page_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && !page_hit) |-> bus_rdata == '0);

   assert_ro_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && page_hit && bus_addr[PAGE_LSB-1:0] == OFS_FABRIC)
      |=> $stable(mode_q) && $stable(dir_q) && $stable(dout_q) && $stable(drive_q));

endmodule

// File: rtl/cfg_io_pad.sv
module cfg_io_pad #(
   parameter int NUM_PINS   = 8,
   parameter bit OD_SUPPORT = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                addr_le,
   input  logic [NUM_PINS-1:0] addr_src,
   input  logic [NUM_PINS-1:0] mode_q,
   input  logic [NUM_PINS-1:0] dir_q,
   input  logic [NUM_PINS-1:0] dout_q,
   input  logic [NUM_PINS-1:0] drive_q,
   input  logic [NUM_PINS-1:0] pld_mask,
   output logic [NUM_PINS-1:0] pad_out,
   output logic [NUM_PINS-1:0] pad_oe
);

   logic [NUM_PINS-1:0] addr_lat_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       addr_lat_q <= '0;
      else if (addr_le) addr_lat_q <= addr_src;
   end

   assert_addr_latch_R10: assert property (@(posedge clk) disable iff (!rst_n)
      addr_le |=> addr_lat_q == $past(addr_src));

   assert_addr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !addr_le |=> $stable(addr_lat_q));

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      logic open_drain;
      logic drive_en;
      logic pin_val;

      if (OD_SUPPORT) begin : g_od
         assign open_drain = drive_q[i];
      end else begin : g_pp
         assign open_drain = 1'b0;
      end

      // Address mode forces output; general mode obeys direction.
      assign drive_en = !pld_mask[i] && (!mode_q[i] || dir_q[i]);
      assign pin_val  = mode_q[i] ? dout_q[i] : addr_lat_q[i];

      always_comb begin
         pad_oe[i]  = 1'b0;
         pad_out[i] = 1'b0;
         if (drive_en) begin
            if (open_drain) begin
               pad_oe[i]  = !pin_val;
               pad_out[i] = 1'b0;
            end else begin
               pad_oe[i]  = 1'b1;
               pad_out[i] = pin_val;
            end
         end
      end

      assert_fabric_tristate_R11: assert property (@(posedge clk) disable iff (!rst_n)
         pld_mask[i] |-> !pad_oe[i] && !pad_out[i]);

      assert_od_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
         (pad_oe[i] && drive_q[i] && OD_SUPPORT) |-> !pad_out[i]);

      assert_input_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (mode_q[i] && !dir_q[i]) |-> !pad_oe[i]);
   end

endmodule

// File: rtl/cfg_io_port.sv
module cfg_io_port #(
   parameter int                NUM_PINS    = 8,
   parameter int                DATA_W      = 8,
   parameter int                ADDR_W      = 16,
   parameter logic [ADDR_W-1:0] BASE_ADDR   = 16'h0300,
   parameter int                SYNC_STAGES = 2,
   parameter bit                OD_SUPPORT  = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic                bus_wr,
   input  logic                bus_rd,
   input  logic [DATA_W-1:0]   bus_wdata,
   output logic [DATA_W-1:0]   bus_rdata,
   input  logic                addr_le,
   input  logic [NUM_PINS-1:0] addr_src,
   input  logic [NUM_PINS-1:0] pld_mask,
   input  logic [NUM_PINS-1:0] mcell_out,
   input  logic [NUM_PINS-1:0] pin_in,
   output logic [NUM_PINS-1:0] pad_out,
   output logic [NUM_PINS-1:0] pad_oe
);

   if (NUM_PINS < 1 || NUM_PINS > DATA_W) begin : g_bad_pins
      $error("cfg_io_port: NUM_PINS must lie in 1..DATA_W");
   end
   if (ADDR_W <= 8) begin : g_bad_addr
      $error("cfg_io_port: ADDR_W must exceed the 8-bit page offset");
   end
   if (BASE_ADDR[7:0] != 8'h00) begin : g_bad_base
      $error("cfg_io_port: BASE_ADDR must be 256-byte aligned");
   end

   logic [NUM_PINS-1:0] pin_sync;
   logic [NUM_PINS-1:0] mode_q;
   logic [NUM_PINS-1:0] dir_q;
   logic [NUM_PINS-1:0] dout_q;
   logic [NUM_PINS-1:0] drive_q;

   cfg_io_sync #(
      .WIDTH  (NUM_PINS),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (pin_in),
      .q_sync  (pin_sync)
   );

   cfg_io_regs #(
      .NUM_PINS   (NUM_PINS),
      .DATA_W     (DATA_W),
      .ADDR_W     (ADDR_W),
      .BASE_ADDR  (BASE_ADDR),
      .OD_SUPPORT (OD_SUPPORT)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_rd    (bus_rd),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .pin_sync  (pin_sync),
      .pld_mask  (pld_mask),
      .mcell_out (mcell_out),
      .mode_q    (mode_q),
      .dir_q     (dir_q),
      .dout_q    (dout_q),
      .drive_q   (drive_q)
   );

   cfg_io_pad #(
      .NUM_PINS   (NUM_PINS),
      .OD_SUPPORT (OD_SUPPORT)
   ) u_pad (
      .clk      (clk),
      .rst_n    (rst_n),
      .addr_le  (addr_le),
      .addr_src (addr_src),
      .mode_q   (mode_q),
      .dir_q    (dir_q),
      .dout_q   (dout_q),
      .drive_q  (drive_q),
      .pld_mask (pld_mask),
      .pad_out  (pad_out),
      .pad_oe   (pad_oe)
   );

endmodule

// File: tb/sim_cfg_io_port.sv
module sim_cfg_io_port;

   localparam int          NP   = 8;
   localparam logic [15:0] BASE = 16'hA500;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [15:0]   bus_addr = '0;
   logic          bus_wr = 1'b0;
   logic          bus_rd = 1'b0;
   logic [7:0]    bus_wdata = '0;
   logic [7:0]    bus_rdata;
   logic          addr_le = 1'b0;
   logic [NP-1:0] addr_src = '0;
   logic [NP-1:0] pld_mask = '0;
   logic [NP-1:0] mcell_out = '0;
   logic [NP-1:0] pin_in = '0;
   logic [NP-1:0] pad_out;
   logic [NP-1:0] pad_oe;

   int n_run = 0;
   int n_fail = 0;

   always #4 clk = ~clk;

   cfg_io_port #(
      .NUM_PINS(NP), .DATA_W(8), .ADDR_W(16), .BASE_ADDR(BASE),
      .SYNC_STAGES(2), .OD_SUPPORT(1'b1)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .addr_le(addr_le), .addr_src(addr_src), .pld_mask(pld_mask),
      .mcell_out(mcell_out), .pin_in(pin_in), .pad_out(pad_out), .pad_oe(pad_oe)
   );

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
      end
   endtask

   task automatic wr_abs(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0; bus_addr = '0;
      #1;
   endtask

   task automatic rd_abs(input logic [15:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #1;
      d = bus_rdata;
      bus_rd = 1'b0; bus_addr = '0;
   endtask

   task automatic wr(input logic [7:0] ofs, input logic [7:0] d);
      wr_abs(BASE | {8'h00, ofs}, d);
   endtask

   task automatic rd_chk(input string tag, input logic [7:0] ofs, input logic [7:0] exp);
      logic [7:0] d;
      rd_abs(BASE | {8'h00, ofs}, d);
      check(tag, d, exp);
   endtask

   task automatic pads_chk(input string tag, input logic [7:0] oe, input logic [7:0] out);
      #1;
      check({tag, " oe"}, pad_oe, oe);
      check({tag, " out"}, pad_out, out);
   endtask

   task automatic t_reset;
      rd_chk("R1 mode", 8'h02, 8'h00);
      rd_chk("R1 dout", 8'h04, 8'h00);
      rd_chk("R1 dir", 8'h06, 8'h00);
      rd_chk("R1 drive", 8'h08, 8'h00);
      pads_chk("R1 pads", 8'hFF, 8'h00);
   endtask

   task automatic t_regs;
      wr(8'h02, 8'h5A); rd_chk("R3 mode", 8'h02, 8'h5A);
      wr(8'h06, 8'hC3); rd_chk("R3 dir", 8'h06, 8'hC3);
      wr(8'h04, 8'h96); rd_chk("R3 dout", 8'h04, 8'h96);
      wr(8'h08, 8'h0F); rd_chk("R3 drive", 8'h08, 8'h0F);
   endtask

   task automatic t_window;
      logic [7:0] d;
      wr_abs(16'hA604, 8'hFF);
      wr_abs(16'hA404, 8'h00);
      rd_chk("R2 dout kept", 8'h04, 8'h96);
      rd_abs(16'hA404, d); check("R2 read below page", d, 8'h00);
      rd_abs(16'hA602, d); check("R2 read above page", d, 8'h00);
   endtask

   task automatic t_unmapped;
      rd_chk("R4 ofs 01", 8'h01, 8'h00);
      rd_chk("R4 ofs 0E", 8'h0E, 8'h00);
      rd_chk("R4 ofs FF", 8'hFF, 8'h00);
      wr(8'h05, 8'h00);
      wr(8'h03, 8'hFF);
      rd_chk("R4 dout kept", 8'h04, 8'h96);
      rd_chk("R4 mode kept", 8'h02, 8'h5A);
   endtask

   task automatic t_push_pull;
      wr(8'h02, 8'hFF); wr(8'h06, 8'h0F); wr(8'h08, 8'h00); wr(8'h04, 8'h35);
      pads_chk("R8 pp", 8'h0F, 8'h05);
   endtask

   task automatic t_open_drain;
      wr(8'h08, 8'hFF);
      pads_chk("R9 od", 8'h0A, 8'h00);
   endtask

   task automatic t_addr_mode;
      wr(8'h02, 8'h00); wr(8'h06, 8'h00); wr(8'h08, 8'h00);
      @(negedge clk); addr_src = 8'h6E; addr_le = 1'b1;
      @(negedge clk); addr_le = 1'b0; addr_src = 8'h11;
      pads_chk("R10 latched", 8'hFF, 8'h6E);
      @(negedge clk);
      pads_chk("R10 held", 8'hFF, 8'h6E);
   endtask

   task automatic t_fabric;
      @(negedge clk); pld_mask = 8'hF0;
      pads_chk("R11 mask", 8'h0F, 8'h0E);
      rd_chk("R5 read", 8'h0A, 8'hF0);
      wr(8'h0A, 8'h00);
      rd_chk("R5 after write", 8'h0A, 8'hF0);
      pads_chk("R5 pads after write", 8'h0F, 8'h0E);
      wr(8'h02, 8'hFF); wr(8'h06, 8'hFF); wr(8'h04, 8'hFF);
      pads_chk("R11 gp mode", 8'h0F, 8'h0F);
   endtask

   task automatic t_mcell;
      @(negedge clk); mcell_out = 8'hA7;
      rd_chk("R6 read", 8'h0C, 8'hA7);
      wr(8'h0C, 8'h00);
      rd_chk("R6 after write", 8'h0C, 8'hA7);
      rd_chk("R6 mode kept", 8'h02, 8'hFF);
   endtask

   task automatic t_pin_levels;
      @(negedge clk); pld_mask = 8'h00;
      repeat (3) @(negedge clk);
      pin_in = 8'h3C;
      rd_chk("R7 one edge", 8'h00, 8'h00);
      rd_chk("R7 two edges", 8'h00, 8'h3C);
      wr(8'h02, 8'h0F);
      rd_chk("R7 addr mode bits", 8'h00, 8'h0C);
      @(negedge clk); pld_mask = 8'h04;
      rd_chk("R7 fabric bit", 8'h00, 8'h08);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_regs();
      t_window();
      t_unmapped();
      t_push_pull();
      t_open_drain();
      t_addr_mode();
      t_fabric();
      t_mcell();
      t_pin_levels();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule